// File: doc/BRIEF.md
# Windowed-Duty PWM Sample Modulator

This block turns a stream of 10-bit unsigned waveform codes into one registered PWM bit. The bit feeds an external RC low-pass filter and amplifier, which together act as a simple DAC. The duty cycle never reaches either supply rail. Each code is remapped onto a high time between 155 and 930 clocks of a 1024-clock period. After filtering, the output therefore stays inside a window of roughly 0.5 V to 3.0 V on a 3.3 V swing, centred near 1.75 V.

A free-running 10-bit counter sets the period. At a nominal 192 MHz clock, one period is about 187.5 kHz, and one sample is played per period. The counter is high while it is below the scaled high time and low for the rest of the period.

Samples arrive over a valid/ready handshake. `smp_ready` is high for exactly one clock per period, in the last clock. A transfer happens only in a cycle where both `smp_valid` and `smp_ready` are high. The producer must hold `smp_valid` and `smp_code` steady until that transfer. If no valid sample is offered at the boundary, the previous code is replayed for the next period. This back-pressure paces the upstream waveform source at the PWM period rate.

Top module: `pwm_window_dac`

## Requirements
- R1: The period counter counts 0 to 1023 and wraps. `smp_ready` is high for exactly one clock in every 1024, the clock in which the counter holds 1023.
- R2: Within each period, `pwm_out` is high for the first h clocks, counting from counter value 0, and low for the remaining 1024 − h clocks. Here h = 155 + floor(c × 776 / 1024), where c is the code in effect for that period. For example, code 300 gives h = 382.
- R3: Code 0 gives the minimum high time of 155 clocks.
- R4: Code 1023 gives a high time of 930 clocks. The high time never reaches 155 + 776 = 931.
- R5: A code is taken only in a cycle where `smp_valid` and `smp_ready` are both high. A `smp_valid` pulse while `smp_ready` is low has no effect on any later period. A code taken at the boundary governs the period that starts on the next clock.
- R6: If `smp_valid` is low in the `smp_ready` cycle, the next period reuses the last code taken.
- R7: While `rst` is high, the counter is held at 0, the held code is mid-scale 512, `pwm_out` is 1 and `smp_ready` is 0. The first period after reset is high for 543 clocks.
- R8: `pwm_out` comes straight from a flip-flop. The high time does not change inside a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_code | input | 10 | Unsigned waveform code from the producer |
| smp_valid | input | 1 | The producer offers `smp_code` |
| smp_ready | output | 1 | One-clock strobe in the last clock of each period |
| pwm_out | output | 1 | Registered PWM bit to the external filter |

## Verification
A code accepted in the `smp_ready` cycle first appears on `pwm_out` in the very next clock, which is counter value 0. From there it governs exactly 1024 clocks. `smp_ready` then returns 1023 clocks after the first clock of that period.

The bench samples on falling edges. It waits for the falling edge on which `smp_ready` is seen high, then records the following 1024 falling edges as counter values 0 through 1023. At each one it counts high clocks, finds the first low clock and notes where the ready strobe falls. The reset case begins counting on the falling edge where reset is released, because the counter already holds 0 there.

// File: rtl/pwm_window_dac_pkg.sv
package pwm_window_dac_pkg;
  localparam int unsigned CODE_W_DEF   = 10;
  localparam int unsigned FLOOR_HI_DEF = 155;
  localparam int unsigned SPAN_HI_DEF  = 776;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [CODE_W-1:0] cnt_o,
  output logic [CODE_W-1:0] cnt_next_o,
  output logic              wrap_o
);
  localparam logic [CODE_W-1:0] LAST = {CODE_W{1'b1}};

  logic [CODE_W-1:0] cnt_q;

  assign cnt_next_o = rst ? '0 : cnt_q + 1'b1;
  assign wrap_o     = (cnt_q == LAST);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_next_o;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> (cnt_q == CODE_W'($past(cnt_q) + 1'b1)));
  assert_reset_cnt_R7: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_code_scaler.sv
module pwm_code_scaler #(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned FLOOR_HI = 155,
  parameter int unsigned SPAN_HI  = 776
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W:0]   high_o
);
  localparam int unsigned PROD_W = CODE_W + $clog2(SPAN_HI + 1);
  localparam int unsigned HI_W   = CODE_W + 1;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;

  always_comb begin
    prod   = PROD_W'(code_i) * PROD_W'(SPAN_HI);
    scaled = prod >> CODE_W;
    high_o = HI_W'(FLOOR_HI) + HI_W'(scaled);
  end
endmodule

// File: rtl/pwm_bit_register.sv
module pwm_bit_register #(
  parameter int unsigned CODE_W  = 10,
  parameter logic        RST_BIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cnt_next_i,
  input  logic [CODE_W:0]   high_next_i,
  output logic              pwm_o
);
  always_ff @(posedge clk) begin
    if (rst) pwm_o <= RST_BIT;
    else     pwm_o <= ({1'b0, cnt_next_i} < high_next_i);
  end
endmodule

// File: rtl/pwm_window_dac.sv
module pwm_window_dac
  import pwm_window_dac_pkg::*;
#(
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter int unsigned FLOOR_HI = FLOOR_HI_DEF,
  parameter int unsigned SPAN_HI  = SPAN_HI_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              smp_valid,
  output logic              smp_ready,
  output logic              pwm_out
);
  localparam int unsigned HI_W     = CODE_W + 1;
  localparam int unsigned MID_CODE = 1 << (CODE_W - 1);
  localparam int unsigned MID_HIGH = FLOOR_HI + ((MID_CODE * SPAN_HI) >> CODE_W);
  localparam int unsigned HI_LIMIT = FLOOR_HI + SPAN_HI;

  logic [CODE_W-1:0] cnt_q, cnt_next;
  logic              wrap;
  logic              take;
  logic [CODE_W-1:0] code_q, code_sel;
  logic [HI_W-1:0]   high_q, high_calc, high_next;

  pwm_period_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cnt_o      (cnt_q),
    .cnt_next_o (cnt_next),
    .wrap_o     (wrap)
  );

  assign smp_ready = wrap;
  assign take      = smp_valid & wrap;
  assign code_sel  = take ? smp_code : code_q;

  pwm_code_scaler #(
    .CODE_W   (CODE_W),
    .FLOOR_HI (FLOOR_HI),
    .SPAN_HI  (SPAN_HI)
  ) u_scale (
    .code_i (code_sel),
    .high_o (high_calc)
  );

  always_comb begin
    if (rst)       high_next = HI_W'(MID_HIGH);
    else if (wrap) high_next = high_calc;
    else           high_next = high_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_W'(MID_CODE);
    end else if (wrap) begin
      code_q <= code_sel;
    end
    high_q <= high_next;
  end

  pwm_bit_register #(
    .CODE_W  (CODE_W),
    .RST_BIT (MID_HIGH > 0)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .cnt_next_i  (cnt_next),
    .high_next_i (high_next),
    .pwm_o       (pwm_out)
  );

  assert_ready_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    smp_ready |=> !smp_ready);
  assert_pwm_compare_R2: assert property (@(posedge clk) disable iff (rst)
    pwm_out == ({1'b0, cnt_q} < high_q));
  assert_high_window_R4: assert property (@(posedge clk) disable iff (rst)
    (high_q >= HI_W'(FLOOR_HI)) && (high_q < HI_W'(HI_LIMIT)));
  assert_code_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !smp_ready |=> $stable(code_q));
  assert_reset_mid_R7: assert property (@(posedge clk)
    rst |=> (code_q == CODE_W'(MID_CODE)));
  assert_high_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(high_q));
endmodule

// File: tb/pwm_window_dac_tb.sv
module pwm_window_dac_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] smp_code = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic       pwm_out;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  pwm_window_dac u_dut (
    .clk       (clk),
    .rst       (rst),
    .smp_code  (smp_code),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .pwm_out   (pwm_out)
  );

  function automatic int exp_high(int code);
    return 155 + ((code * 776) >> 10);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Record one period: sample k is counter value k.
  task automatic measure(bit pre_wait, int exp_h, string tag);
    int highs = 0;
    int first_low = -1;
    int rdy_cnt = 0;
    int rdy_pos = -1;
    for (int i = 0; i < 1024; i++) begin
      if (pre_wait || i > 0) @(negedge clk);
      if (i == 0) smp_valid = 1'b0;
      if (pwm_out) highs++;
      else if (first_low < 0) first_low = i;
      if (smp_ready) begin rdy_cnt++; rdy_pos = i; end
    end
    check(highs == exp_h, {tag, " high count"}, highs, exp_h);
    check(first_low == exp_h, {tag, " high run starts at count 0"}, first_low, exp_h);
    check(rdy_cnt == 1 && rdy_pos == 1023, {tag, " R1 ready position"}, rdy_pos, 1023);
  endtask

  task automatic wait_ready();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!smp_ready && n < 3000);
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b1, "R7 pwm during reset", pwm_out, 1);
    check(smp_ready == 1'b0, "R7 ready during reset", smp_ready, 0);
    rst = 1'b0;
    measure(1'b0, 543, "R7 first period mid-scale");
  endtask

  // R5: valid held until the boundary transfer
  task automatic test_code(int code, string tag);
    smp_code  = 10'(code);
    smp_valid = 1'b1;
    wait_ready();
    measure(1'b1, exp_high(code), tag);
  endtask

  task automatic test_ignore_and_hold(int prev_code);
    repeat (200) @(negedge clk);
    smp_code  = 10'd0;
    smp_valid = 1'b1;
    check(smp_ready == 1'b0, "R5 ready low mid-period", smp_ready, 0);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_code  = 10'd1023;
    wait_ready();
    measure(1'b1, exp_high(prev_code), "R5 R6 stray valid ignored, code held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_code(0, "R3 R2 code 0");
    test_code(1023, "R4 R2 code 1023");
    test_code(300, "R2 code 300");
    test_ignore_and_hold(300);
    test_code(512, "R2 R8 code 512");
    test_code(1, "R2 code 1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule